// File: doc/BRIEF.md
# Bus Cycle Cacheability Indicator

This block drives the cacheability indicator of a processor bus interface. The indicator is a cycle-definition output. It is meaningful only when the cache runs in write-back mode, and it tells the system whether the bus cycle now starting belongs to a cacheable transfer. Each request carries a descriptor: a cycle type, a cacheable flag, a locked flag, a snoop-writeback flag, and the cache operating mode. The block also watches the address strobe, the two ready inputs, back-off and hold acknowledge.

The indicator is active-low. Its level is classified from the descriptor in the same clock as the address strobe. That level is then held until the cycle ends with a ready. An output-enable sits beside the indicator and stands in for a tri-state driver. The enable drops in write-through mode and while hold is acknowledged. It also drops from one clock after back-off is sampled.

Top module: `cache_ind_top`

## Requirements
- R1: With `wb_mode` = 0 (write-through), `cache_oe` is 0 in every cycle.
- R2: A data read (`req_type` 0) or code fetch (`req_type` 1) with `req_cacheable` = 1 and `req_locked` = 0 drives `cache_n` = 0.
- R3: A write-back/copy-back cycle (`req_type` 2) drives `cache_n` = 0 when `req_locked` = 0. When `req_locked` = 1 it drives `cache_n` = 0 only if `req_snoop_wb` = 1.
- R4: These cycles drive `cache_n` = 1: a data read or code fetch that is non-cacheable or locked, translation-buffer replacement (3), I/O (4), special (5), write-through write (6) and the unused code 7.
- R5: The classified level appears on `cache_n` combinationally in the clock in which `ads_n` = 0.
- R6: After the strobe, `cache_n` keeps the classified level through the clock in which `rdy_n` or `brdy_n` is 0. Descriptor changes during that time have no effect.
- R7: After the clock edge on which a ready is sampled, and with no new strobe, `cache_n` = 1 with `cache_oe` = 1.
- R8: `boff_n` = 0 sampled on an edge drops `cache_oe` in the following clock. The enable stays low until one clock after `boff_n` returns to 1. The back-off abandons the cycle in progress, so the indicator comes back inactive.
- R9: `hlda` = 1 drops `cache_oe` in the same clock.
- R10: While `cache_oe` = 0, `cache_n` reads 1.
- R11: After reset, and with no strobe, `cache_n` = 1 and `cache_oe` = 1 in write-back mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | 1 = write-back mode, 0 = write-through |
| req_type | input | 3 | Cycle type code |
| req_cacheable | input | 1 | Request is internally cacheable |
| req_locked | input | 1 | Request is part of a locked sequence |
| req_snoop_wb | input | 1 | Write-back caused by an external snoop |
| ads_n | input | 1 | Address strobe, active low |
| rdy_n | input | 1 | Non-burst ready, active low |
| brdy_n | input | 1 | Burst ready, active low |
| boff_n | input | 1 | Back-off, active low |
| hlda | input | 1 | Hold acknowledge |
| cache_n | output | 1 | Cacheability indicator, active low |
| cache_oe | output | 1 | Indicator output-enable (0 = floating) |

## Verification
A wrong held level or a stale busy flag shows at the ports within one clock. The indicator would change in the clock after the strobe, or it would stay active in the idle clock after the ready. A wrong back-off register shows as an enable that drops in the back-off clock itself, or that returns a clock early or late. A classification fault shows in the strobe clock of the affected descriptor. For that reason every type/flag combination is swept, with both the ready and the burst-ready ending.

// File: rtl/cache_ind_pkg.sv
package cache_ind_pkg;
  localparam int TYPE_W = 3;

  typedef enum logic [TYPE_W-1:0] {
    CYC_DATA_RD  = 3'd0,
    CYC_CODE_RD  = 3'd1,
    CYC_WRBACK   = 3'd2,
    CYC_TLB_RD   = 3'd3,
    CYC_IO       = 3'd4,
    CYC_SPECIAL  = 3'd5,
    CYC_WT_WRITE = 3'd6,
    CYC_RSVD     = 3'd7
  } cyc_type_e;
endpackage

// File: rtl/cache_ind_classify.sv
module cache_ind_classify
  import cache_ind_pkg::*;
(
  input  logic [TYPE_W-1:0] req_type,
  input  logic              req_cacheable,
  input  logic              req_locked,
  input  logic              req_snoop_wb,
  output logic              cls_active
);
  cyc_type_e kind;

  always_comb begin
    kind       = cyc_type_e'(req_type);
    cls_active = 1'b0;
    unique case (kind)
      CYC_DATA_RD,
      CYC_CODE_RD:  cls_active = req_cacheable & ~req_locked;
      // a snoop write-back may break into a locked sequence
      CYC_WRBACK:   cls_active = ~req_locked | req_snoop_wb;
      CYC_TLB_RD,
      CYC_IO,
      CYC_SPECIAL,
      CYC_WT_WRITE,
      CYC_RSVD:     cls_active = 1'b0;
      default:      cls_active = 1'b0;
    endcase
  end
endmodule

// File: rtl/cache_ind_tracker.sv
module cache_ind_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic ads_n,
  input  logic rdy_n,
  input  logic brdy_n,
  input  logic abort,
  input  logic cls_active,
  output logic busy,
  output logic held_active
);
  logic busy_d, held_d;
  logic load, done;

  assign load = ~ads_n;
  assign done = busy & (~rdy_n | ~brdy_n);

  always_comb begin
    busy_d = busy;
    held_d = held_active;
    if (abort) begin
      busy_d = 1'b0;
    end else if (load) begin
      busy_d = 1'b1;
      held_d = cls_active;
    end else if (done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      held_active <= 1'b0;
    end else begin
      busy        <= busy_d;
      held_active <= held_d;
    end
  end
endmodule

// File: rtl/cache_ind_float.sv
module cache_ind_float (
  input  logic clk,
  input  logic rst_n,
  input  logic wb_mode,
  input  logic boff_n,
  input  logic hlda,
  output logic boff_seen,
  output logic drive_en
);
  logic boff_d;

  always_comb boff_d = ~boff_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boff_seen <= 1'b0;
    else        boff_seen <= boff_d;
  end

  assign drive_en = wb_mode & ~hlda & ~boff_seen;
endmodule

// File: rtl/cache_ind_top.sv
module cache_ind_top
  import cache_ind_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_mode,
  input  logic [TYPE_W-1:0] req_type,
  input  logic              req_cacheable,
  input  logic              req_locked,
  input  logic              req_snoop_wb,
  input  logic              ads_n,
  input  logic              rdy_n,
  input  logic              brdy_n,
  input  logic              boff_n,
  input  logic              hlda,
  output logic              cache_n,
  output logic              cache_oe
);
  logic cls_active, busy, held_active, boff_seen, drive_en, level;

  cache_ind_classify u_cls (
    .req_type      (req_type),
    .req_cacheable (req_cacheable),
    .req_locked    (req_locked),
    .req_snoop_wb  (req_snoop_wb),
    .cls_active    (cls_active)
  );

  cache_ind_float u_flt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_mode   (wb_mode),
    .boff_n    (boff_n),
    .hlda      (hlda),
    .boff_seen (boff_seen),
    .drive_en  (drive_en)
  );

  cache_ind_tracker u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ads_n       (ads_n),
    .rdy_n       (rdy_n),
    .brdy_n      (brdy_n),
    .abort       (boff_seen | ~boff_n),
    .cls_active  (cls_active),
    .busy        (busy),
    .held_active (held_active)
  );

  always_comb begin
    if (!ads_n) level = cls_active;
    else        level = busy & held_active;
  end

  assign cache_oe = drive_en;
  assign cache_n  = ~(level & drive_en);
endmodule

// File: rtl/cache_ind_checker.sv
module cache_ind_checker
  import cache_ind_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wb_mode,
  input logic [TYPE_W-1:0] req_type,
  input logic              ads_n,
  input logic              rdy_n,
  input logic              brdy_n,
  input logic              boff_n,
  input logic              hlda,
  input logic              cache_n,
  input logic              cache_oe
);
  a_r1_wt_float: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_mode |-> !cache_oe);

  a_r4_io_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && req_type == CYC_IO) |-> cache_n);

  a_r6_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && rdy_n && brdy_n && boff_n && cache_oe) ##1 (ads_n && cache_oe)
      |-> cache_n == $past(cache_n));

  a_r7_idle_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_n && (!rdy_n || !brdy_n)) ##1 (ads_n && cache_oe) |-> cache_n);

  a_r8_boff_float: assert property (@(posedge clk) disable iff (!rst_n)
    !boff_n |=> !cache_oe);

  a_r9_hlda_float: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !cache_oe);

  a_r10_float_high: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_oe |-> cache_n);
endmodule

bind cache_ind_top cache_ind_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wb_mode  (wb_mode),
  .req_type (req_type),
  .ads_n    (ads_n),
  .rdy_n    (rdy_n),
  .brdy_n   (brdy_n),
  .boff_n   (boff_n),
  .hlda     (hlda),
  .cache_n  (cache_n),
  .cache_oe (cache_oe)
);

// File: tb/test_cache_ind_top.sv
module test_cache_ind_top;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, wb_mode, req_cacheable, req_locked, req_snoop_wb;
  logic ads_n, rdy_n, brdy_n, boff_n, hlda;
  logic [2:0] req_type;
  logic cache_n, cache_oe;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  cache_ind_top i_cache_ind_top (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .req_type(req_type),
    .req_cacheable(req_cacheable), .req_locked(req_locked),
    .req_snoop_wb(req_snoop_wb), .ads_n(ads_n), .rdy_n(rdy_n),
    .brdy_n(brdy_n), .boff_n(boff_n), .hlda(hlda),
    .cache_n(cache_n), .cache_oe(cache_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act_n, input logic act_oe,
                       input logic exp_n, input logic exp_oe);
    checks++;
    if (act_n !== exp_n || act_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s: cache_n/oe = %b/%b expected %b/%b", req, act_n, act_oe, exp_n, exp_oe);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  function automatic logic expect_active(int t, logic c, logic l, logic s);
    if (t == 0 || t == 1) return c & ~l;
    if (t == 2) return ~l | s;
    return 1'b0;
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wb_mode = 1'b1; req_type = 3'd0; req_cacheable = 1'b0;
    req_locked = 1'b0; req_snoop_wb = 1'b0; ads_n = 1'b1; rdy_n = 1'b1;
    brdy_n = 1'b1; boff_n = 1'b1; hlda = 1'b0;
    tick; tick;
    #1 check("R11 reset", cache_n, cache_oe, 1'b1, 1'b1);
    tick; rst_n = 1'b1;
    tick; #1 check("R11 after reset", cache_n, cache_oe, 1'b1, 1'b1);

    // R2 R3 R4 R5 R6 R7: full sweep of descriptor, both endings
    for (int t = 0; t < 8; t++) begin
      for (int f = 0; f < 16; f++) begin
        logic c, l, s, e, use_burst;
        c = f[0]; l = f[1]; s = f[2]; use_burst = f[3];
        e = expect_active(t, c, l, s);
        tick;
        req_type = 3'(t); req_cacheable = c; req_locked = l; req_snoop_wb = s;
        ads_n = 1'b0;
        #1 check("R2/R3/R4/R5 strobe clock", cache_n, cache_oe, ~e, 1'b1);
        tick;
        ads_n = 1'b0 ^ 1'b1;
        req_type = 3'(7 - t); req_cacheable = ~c; req_locked = ~l; req_snoop_wb = ~s;
        #1 check("R6 hold after strobe", cache_n, cache_oe, ~e, 1'b1);
        tick;
        if (use_burst) brdy_n = 1'b0; else rdy_n = 1'b0;
        #1 check("R6 hold in ready clock", cache_n, cache_oe, ~e, 1'b1);
        tick;
        brdy_n = 1'b1; rdy_n = 1'b1;
        #1 check("R7 idle after ready", cache_n, cache_oe, 1'b1, 1'b1);
      end
    end

    // R8: back-off during a cacheable read
    tick;
    req_type = 3'd0; req_cacheable = 1'b1; req_locked = 1'b0; ads_n = 1'b0;
    #1 check("R5 strobe before back-off", cache_n, cache_oe, 1'b0, 1'b1);
    tick; ads_n = 1'b1; boff_n = 1'b0;
    #1 check("R8 still driven in back-off clock", cache_n, cache_oe, 1'b0, 1'b1);
    tick;
    #1 check("R8 float one clock later", cache_n, cache_oe, 1'b1, 1'b0);
    tick; boff_n = 1'b1;
    #1 check("R8 float in release clock", cache_n, cache_oe, 1'b1, 1'b0);
    tick;
    #1 check("R8 driven inactive after release", cache_n, cache_oe, 1'b1, 1'b1);

    // R9 R10: hold acknowledge during a held cycle
    tick; req_type = 3'd2; req_locked = 1'b0; ads_n = 1'b0;
    tick; ads_n = 1'b1; hlda = 1'b1;
    #1 check("R9/R10 hlda float", cache_n, cache_oe, 1'b1, 1'b0);
    tick; hlda = 1'b0;
    #1 check("R6 level back after hlda", cache_n, cache_oe, 1'b0, 1'b1);
    tick; rdy_n = 1'b0;
    tick; rdy_n = 1'b1;
    #1 check("R7 idle after hlda cycle", cache_n, cache_oe, 1'b1, 1'b1);

    // R1: write-through mode with a cacheable strobe
    tick; wb_mode = 1'b0; req_type = 3'd1; req_cacheable = 1'b1; ads_n = 1'b0;
    #1 check("R1 write-through strobe", cache_n, cache_oe, 1'b1, 1'b0);
    tick; ads_n = 1'b1;
    #1 check("R1 write-through held", cache_n, cache_oe, 1'b1, 1'b0);
    tick; brdy_n = 1'b0;
    tick; brdy_n = 1'b1; wb_mode = 1'b1;
    #1 check("R1 back in write-back idle", cache_n, cache_oe, 1'b1, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule